// File: doc/BRIEF.md
# Single Wait-State Acknowledge Generator

This block sits beside a memory-bus master and does two jobs for it. It halves a fast reference clock to make the bus clock the master runs on. It also answers the master's active-low RAM chip-select with an active-low transfer-acknowledge that arrives one bus-clock period late. The master samples the acknowledge on the rising edge of the bus clock. A memory cycle that would finish in two bus clocks therefore takes three, which gives slow memories exactly one wait state.

The acknowledge passes through two flops that both advance on the falling edge of the bus clock. The first flop captures the chip-select and is brought out as a probe output. The second flop copies the first and drives the acknowledge. A DMA-acknowledge input forces the acknowledge inactive without delay. An active-low master reset holds the bus clock, the probe and the acknowledge high. A separate auxiliary clock input is passed straight through as a buffered copy and an inverted copy.

The whole block runs in the fast-clock domain. The bus-clock falling edge is represented by a one-cycle enable, so no derived clock drives any flop.

Top module: `wait_ack_gen`

## Requirements
- R1: After reset is released, `bus_clk` toggles on every rising edge of `ref_clk`, so it runs at half the reference rate. It is low after the first edge that follows the release and high after the second.
- R2: On every `ref_clk` edge at which `mrst_n` is low, `bus_clk`, `cap_probe` and `xfer_ack_n` are set high. This includes a reset that arrives in the middle of a memory cycle.
- R3: `cap_probe` loads the value of `ram_sel_n` only on a bus-clock falling edge, which is a `ref_clk` edge at which `bus_clk` changes from 1 to 0. At every other edge it holds its value.
- R4: On each bus-clock falling edge, `xfer_ack_n` takes the value that `cap_probe` held before that edge. After `ram_sel_n` is captured low, the acknowledge therefore goes low one bus period (two `ref_clk` cycles) later. The bus-clock rising edge in between still sees the acknowledge high.
- R5: A low pulse on `ram_sel_n` that starts and ends between two bus-clock falling edges has no effect on `cap_probe` or `xfer_ack_n`.
- R6: While `dma_ack` is 1, `xfer_ack_n` is 1 in the same cycle, without waiting for a clock edge, and the second stage is preset to 1. After `dma_ack` drops, `xfer_ack_n` stays 1 until the next bus-clock falling edge reloads it from `cap_probe`.
- R7: When `ram_sel_n` returns high, `cap_probe` goes high at the next bus-clock falling edge and `xfer_ack_n` goes high one bus period later.
- R8: `aux_clk_buf` equals `aux_clk_in` and `aux_clk_inv` equals its inverse at all times.
- R9: If reset is released while `ram_sel_n` is held low, the first edge after release is a bus-clock falling edge. That edge captures the low into `cap_probe`, and `xfer_ack_n` goes low one bus period later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | Fast reference clock, twice the bus-clock rate |
| mrst_n | input | 1 | Master reset, active low, synchronous to ref_clk |
| ram_sel_n | input | 1 | RAM chip-select from the bus master, active low |
| dma_ack | input | 1 | DMA acknowledge; when 1 it forces the transfer-acknowledge inactive |
| aux_clk_in | input | 1 | Unrelated clock to be passed through |
| bus_clk | output | 1 | Divided bus clock (reference / 2) |
| cap_probe | output | 1 | First pipeline stage: chip-select as captured on the bus-clock falling edge |
| xfer_ack_n | output | 1 | Transfer-acknowledge to the master, active low |
| aux_clk_buf | output | 1 | Buffered copy of aux_clk_in |
| aux_clk_inv | output | 1 | Inverted copy of aux_clk_in |

## Verification
The chip-select is driven low at two different bus-clock phases. When it falls just before a bus-clock falling edge, the probe drops after one reference cycle and the acknowledge two cycles after that. When it falls just before a rising edge, nothing moves until the following falling edge. Together these show that capture happens only on the falling edge. A short low pulse placed wholly between falling edges must leave both stages high. A release followed by a new select one bus period later shows that each stage updates on its own schedule. DMA is raised while the acknowledge is low and dropped in the rising-edge phase, which separates the immediate forcing from the preset that stays held. A reset in the middle of a cycle, released with the chip-select still low, shows that the pipeline restarts cleanly.

// File: rtl/wag_pkg.sv
// Shared definitions for the wait-state acknowledge generator.
// Assumes every active-low signal in the block idles at logic 1.
package wag_pkg;
    // Level of an inactive active-low strobe, used for all presets.
    localparam logic IDLE_LVL = 1'b1;

    // State of the two-stage acknowledge pipeline.
    typedef struct packed {
        logic capt;   // first stage: captured chip-select
        logic ack;    // second stage: delayed acknowledge
    } ack_pipe_t;
endpackage

// File: rtl/wag_clk_halver.sv
// Divide-by-two of the reference clock, built as a toggle flop.
// It also produces a one-cycle enable for the bus-clock falling edge.
// The enable is high in the reference cycle whose closing edge moves
// the bus clock from 1 to 0.
// Assumes a synchronous active-low reset; the divided clock is held high
// while reset is asserted.
module wag_clk_halver
    import wag_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    output logic div_clk,
    output logic fall_en
);
    logic div_q;

    // Toggle the divided clock on each reference edge; preset high in reset.
    always_ff @(posedge clk) begin
        if (!rst_n) div_q <= IDLE_LVL;
        else        div_q <= ~div_q;
    end

    // The next reference edge is a falling bus-clock edge exactly when div_q is high.
    assign fall_en = div_q;
    assign div_clk = div_q;

    // R1: once out of reset, the divided clock changes on every edge.
    a_r1_toggle: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (div_q != $past(div_q)));
endmodule

// File: rtl/wag_ack_pipe.sv
// Two-stage shift register that delays the chip-select by one bus period.
// Both stages advance only when fall_en is high. The second stage is
// preset whenever the override is high, and the acknowledge output is also
// gated by the override without a clock edge.
// Assumes fall_en is high for exactly one reference cycle per bus period.
module wag_ack_pipe
    import wag_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic fall_en,
    input  logic sel_n,
    input  logic force_idle,
    output logic capt_q,
    output logic ack_n
);
    ack_pipe_t st;

    // First stage: capture chip-select on a bus-clock falling edge.
    always_ff @(posedge clk) begin
        if (!rst_n)       st.capt <= IDLE_LVL;
        else if (fall_en) st.capt <= sel_n;
    end

    // Second stage: preset on override, otherwise shift from the first stage.
    always_ff @(posedge clk) begin
        if (!rst_n)          st.ack <= IDLE_LVL;
        else if (force_idle) st.ack <= IDLE_LVL;
        else if (fall_en)    st.ack <= st.capt;
    end

    // Combinational override so forcing acts within the same cycle.
    assign ack_n  = st.ack | force_idle;
    assign capt_q = st.capt;

    // R3: the first stage loads the chip-select on a falling edge.
    a_r3_capture: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(fall_en)) |-> (st.capt == $past(sel_n)));

    // R3: the first stage holds between falling edges.
    a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(fall_en)) |-> $stable(st.capt));

    // R4: the second stage takes the first stage's old value.
    a_r4_shift: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(fall_en) && !$past(force_idle)) |-> (st.ack == $past(st.capt)));

    // R6: an override in the previous cycle leaves the second stage preset.
    a_r6_preset: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(force_idle)) |-> st.ack);
endmodule

// File: rtl/wag_clk_passthru.sv
// True and inverted pass-through of an unrelated clock input.
// Assumes no timing relation to the reference clock; purely combinational.
module wag_clk_passthru (
    input  logic clk_in,
    output logic clk_true,
    output logic clk_comp
);
    // Direct copy and its complement.
    assign clk_true = clk_in;
    assign clk_comp = ~clk_in;
endmodule

// File: rtl/wait_ack_gen.sv
// Top level of the single wait-state acknowledge generator.
// It divides the reference clock by two to make the bus clock, and it
// delays the RAM chip-select through a two-stage pipeline clocked by the
// bus-clock falling-edge enable. It also passes an auxiliary clock through.
// Assumes mrst_n is synchronous to ref_clk.
module wait_ack_gen (
    input  logic ref_clk,
    input  logic mrst_n,
    input  logic ram_sel_n,
    input  logic dma_ack,
    input  logic aux_clk_in,
    output logic bus_clk,
    output logic cap_probe,
    output logic xfer_ack_n,
    output logic aux_clk_buf,
    output logic aux_clk_inv
);
    logic fall_en;

    wag_clk_halver u_div (
        .clk     (ref_clk),
        .rst_n   (mrst_n),
        .div_clk (bus_clk),
        .fall_en (fall_en)
    );

    wag_ack_pipe u_pipe (
        .clk        (ref_clk),
        .rst_n      (mrst_n),
        .fall_en    (fall_en),
        .sel_n      (ram_sel_n),
        .force_idle (dma_ack),
        .capt_q     (cap_probe),
        .ack_n      (xfer_ack_n)
    );

    wag_clk_passthru u_pass (
        .clk_in   (aux_clk_in),
        .clk_true (aux_clk_buf),
        .clk_comp (aux_clk_inv)
    );

    // R4: the acknowledge can only fall one bus period after the probe fell.
    a_r4_ack_after_probe: assert property (@(posedge ref_clk) disable iff (!mrst_n)
        $fell(xfer_ack_n) |-> ($past(cap_probe) == 1'b0 && $past(cap_probe, 2) == 1'b0));
endmodule

// File: tb/tb_wait_ack_gen.sv
module tb_wait_ack_gen;
    localparam int CLK_PERIOD = 10;
    localparam logic [2:0] M_ALL = 3'b111;
    localparam logic [2:0] M_PA  = 3'b011;
    localparam logic [2:0] M_A   = 3'b001;

    logic ref_clk = 1'b0;
    logic mrst_n, ram_sel_n, dma_ack, aux_clk_in;
    logic bus_clk, cap_probe, xfer_ack_n, aux_clk_buf, aux_clk_inv;

    always #(CLK_PERIOD/2) ref_clk = ~ref_clk;

    wait_ack_gen dut (
        .ref_clk(ref_clk), .mrst_n(mrst_n), .ram_sel_n(ram_sel_n),
        .dma_ack(dma_ack), .aux_clk_in(aux_clk_in), .bus_clk(bus_clk),
        .cap_probe(cap_probe), .xfer_ack_n(xfer_ack_n),
        .aux_clk_buf(aux_clk_buf), .aux_clk_inv(aux_clk_inv)
    );

    int cyc = 0;
    always @(posedge ref_clk) cyc <= cyc + 1;

    typedef struct {
        int         at;
        logic [2:0] val;   // {bus_clk, cap_probe, xfer_ack_n}
        logic [2:0] mask;
        string      tag;
    } exp_t;
    exp_t sb[$];
    int n_chk = 0;
    int n_err = 0;
    bit done = 0;

    task automatic check(string tag, logic [2:0] act, logic [2:0] exp, logic [2:0] mask);
        n_chk++;
        if ((act & mask) !== (exp & mask)) begin
            n_err++;
            $display("FAIL %s at cycle %0d: actual=%b expected=%b mask=%b", tag, cyc, act, exp, mask);
        end
    endtask

    // Driver side: queue an expected output set dly reference cycles ahead.
    task automatic push(int dly, logic bc, logic pr, logic ak, logic [2:0] mask, string tag);
        exp_t e;
        e.at = cyc + dly; e.val = {bc, pr, ak}; e.mask = mask; e.tag = tag;
        sb.push_back(e);
    endtask

    task automatic wait_bclk(logic lvl);
        do @(negedge ref_clk); while (bus_clk !== lvl);
    endtask

    // Monitor: compare the outputs at mid-cycle against due expectations.
    always @(negedge ref_clk) begin
        for (int i = sb.size() - 1; i >= 0; i--) begin
            if (sb[i].at == cyc) begin
                check(sb[i].tag, {bus_clk, cap_probe, xfer_ack_n}, sb[i].val, sb[i].mask);
                sb.delete(i);
            end
        end
    end

    initial begin
        #(CLK_PERIOD * 20000);
        if (!done) begin
            n_chk++; n_err++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        mrst_n = 1'b0; ram_sel_n = 1'b1; dma_ack = 1'b0; aux_clk_in = 1'b0;
        repeat (3) @(negedge ref_clk);
        // R2: reset state
        push(1, 1, 1, 1, M_ALL, "R2 reset state");
        @(negedge ref_clk);
        mrst_n = 1'b1;
        // R1: frequency and phase after release
        for (int k = 1; k <= 8; k++) push(k, (k % 2 == 1) ? 1'b0 : 1'b1, 1, 1, M_ALL, "R1 divide by two");
        repeat (8) @(negedge ref_clk);

        // Select falls just before a bus-clock falling edge
        wait_bclk(1'b1);
        ram_sel_n = 1'b0;
        push(1, 0, 0, 1, M_ALL, "R3 capture on falling edge");
        push(2, 1, 0, 1, M_ALL, "R4 rising edge sees wait state");
        push(3, 0, 0, 0, M_ALL, "R4 ack one period later");
        push(4, 1, 0, 0, M_ALL, "R4 ack seen at next rising");
        repeat (6) @(negedge ref_clk);
        ram_sel_n = 1'b1;
        push(1, 0, 1, 0, M_ALL, "R7 probe releases first");
        push(2, 1, 1, 0, M_ALL, "R7 ack still low");
        push(3, 0, 1, 1, M_ALL, "R7 ack releases one period later");
        repeat (4) @(negedge ref_clk);

        // Select falls just before a bus-clock rising edge
        wait_bclk(1'b0);
        ram_sel_n = 1'b0;
        push(1, 1, 1, 1, M_ALL, "R3 no capture on rising edge");
        push(2, 0, 0, 1, M_ALL, "R3 capture at next falling edge");
        push(3, 1, 0, 1, M_ALL, "R4 wait state");
        push(4, 0, 0, 0, M_ALL, "R4 ack low");
        repeat (4) @(negedge ref_clk);
        wait_bclk(1'b1);
        ram_sel_n = 1'b1;
        repeat (4) @(negedge ref_clk);

        // Short pulse between falling edges
        wait_bclk(1'b0);
        ram_sel_n = 1'b0;
        for (int k = 1; k <= 4; k++) push(k, 0, 1, 1, M_PA, "R5 short pulse ignored");
        @(negedge ref_clk);
        ram_sel_n = 1'b1;
        repeat (4) @(negedge ref_clk);

        // Back-to-back cycles
        wait_bclk(1'b1);
        ram_sel_n = 1'b0;
        repeat (4) @(negedge ref_clk);
        ram_sel_n = 1'b1;
        push(1, 0, 1, 0, M_PA, "R7 back-to-back release");
        push(3, 0, 0, 1, M_A,  "R7 back-to-back ack high");
        repeat (2) @(negedge ref_clk);
        ram_sel_n = 1'b0;
        push(1, 0, 0, 1, M_PA, "R3 second cycle capture");
        push(3, 0, 0, 0, M_PA, "R4 second cycle ack");
        repeat (4) @(negedge ref_clk);

        // DMA override while the acknowledge is low
        wait_bclk(1'b0);
        dma_ack = 1'b1;
        #1 check("R6 immediate force", {2'b00, xfer_ack_n}, 3'b001, M_A);
        for (int k = 1; k <= 3; k++) push(k, 0, 0, 1, M_PA, "R6 forced high");
        repeat (4) @(negedge ref_clk);
        dma_ack = 1'b0;
        #1 check("R6 preset held after drop", {2'b00, xfer_ack_n}, 3'b001, M_A);
        push(1, 1, 0, 1, M_ALL, "R6 held until falling edge");
        push(2, 0, 0, 0, M_ALL, "R6 reload from probe");
        repeat (3) @(negedge ref_clk);

        // Reset in the middle of a cycle, released with select still low
        mrst_n = 1'b0;
        push(1, 1, 1, 1, M_ALL, "R2 mid-cycle reset");
        push(2, 1, 1, 1, M_ALL, "R2 reset held");
        repeat (2) @(negedge ref_clk);
        mrst_n = 1'b1;
        push(1, 0, 0, 1, M_ALL, "R9 capture on first edge");
        push(2, 1, 0, 1, M_ALL, "R9 wait state");
        push(3, 0, 0, 0, M_ALL, "R9 ack low");
        repeat (4) @(negedge ref_clk);
        ram_sel_n = 1'b1;
        repeat (6) @(negedge ref_clk);

        // R8: pass-through
        for (int i = 0; i < 4; i++) begin
            aux_clk_in = i[0];
            #1 check("R8 pass-through", {1'b0, aux_clk_buf, aux_clk_inv}, {1'b0, i[0], ~i[0]}, M_PA);
            @(negedge ref_clk);
        end

        while (sb.size() != 0) @(negedge ref_clk);
        done = 1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule